// File: doc/BRIEF.md
# Four-Channel PWM Generator with Brake Override

The block drives four pulse-width modulated outputs from one shared period counter. Each channel has its own compare value. An output is high while the counter is below that value. Software programs the block through a small write/read register port. Period and compare values first go into shadow registers. They reach the active registers only when a transfer is requested, and then only at the end of a PWM period, or at once while the generator is stopped. Software polls the transfer flag to learn when the load has happened.

A brake function can override all four outputs with a per-channel forced level. A two-bit mode selects the brake source: permanent (a software brake), whenever the generator is stopped, or from an external pin. The pin has selectable polarity and passes through a two-flop synchronizer. An optional sticky latch can hold a short pin pulse until software clears it. This keeps the return from brake to run clean.

Top module: `pwmb_top`

## Requirements
- R1: After reset every register reads 0 (control at address 0, brake configuration at address 1, period shadow at address 2, compare shadows at addresses 3 to 6 for channels 0 to 3), and all outputs are low.
- R2: The counter runs from 0 up to the active period and wraps to 0, so one PWM period lasts period+1 cycles. While stopped the counter holds 0. Output i is high while the counter is below compare i: a compare of 0 gives constant low, and a compare above the period gives constant high. Outputs are registered, one cycle behind the counter.
- R3: Writing the control register (bit 0 run, bit 1 latch enable, bit 2 latch clear when written 1, bit 6 transfer) with bit 6 set makes bit 6 read 1. Shadow values are copied to the active registers, and bit 6 clears, at the next period wrap while running, or on the next cycle while stopped.
- R4: With brake enable (configuration bit 4) at 0 no brake is applied, whatever the other configuration bits hold.
- R5: Mode code {bit 7, bit 5} = 00 with enable set brakes permanently.
- R6: Mode 01 brakes exactly while the run bit is 0, and the pin has no effect.
- R7: Mode 10 brakes while the synchronized pin is active, and the run bit has no effect. Configuration bit 6 selects the active pin level: 0 is low and 1 is high.
- R8: The reserved mode 11 applies no brake.
- R9: While braked, output i takes the level in configuration bit i (bits 3 to 0 for channels 3 to 0).
- R10: With latch enable set, an active synchronized pin sets a sticky latch, read back on control bit 7. The latch holds the pin brake after the pin goes inactive, until software writes control with bit 2 set.
- R11: A pin change reaches the outputs on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| brake_pin | input | 1 | External brake pin, asynchronous |
| pwm_o | output | 4 | PWM outputs, channel 0 in bit 0 |

## Verification
The bench builds the block with its default parameters: four channels and an 8-bit data width. It keeps shadow periods below 16 and compare values up to 17, so there are many period wraps, transfers caught mid-period, and compares that lie above the period or are zero. A cycle-level reference model in the bench follows every random mix of mode codes (the reserved one included), polarity flips, single-cycle pin pulses, latch clears and run toggles. Directed sequences pin down the pin latency, the latch hold and the timing of transfers while stopped and while running.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_BRK  = 1;
    localparam int ADDR_PER  = 2;
    localparam int ADDR_CMP0 = 3;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_LEN  = 1;
    localparam int CTRL_CLR  = 2;
    localparam int CTRL_XFER = 6;
    localparam int CTRL_LST  = 7;

    localparam int BRK_MODE_HI = 7;
    localparam int BRK_POL     = 6;
    localparam int BRK_MODE_LO = 5;
    localparam int BRK_EN      = 4;

    typedef enum logic [1:0] {
        BM_ALWAYS = 2'b00,
        BM_IDLE   = 2'b01,
        BM_PIN    = 2'b10,
        BM_RSVD   = 2'b11
    } brake_mode_e;
endpackage

// File: rtl/pwmb_regs.sv
module pwmb_regs
    import pwmb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int AW  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [DW-1:0]           rd_data,
    input  logic                    latch_i,
    output logic                    run_o,
    output logic                    len_o,
    output logic                    clr_o,
    output logic [7:0]              cfg_o,
    output logic [DW-1:0]           cnt_o,
    output logic [NCH-1:0][DW-1:0]  cmp_o
);
    typedef struct packed {
        logic                   run;
        logic                   len;
        logic                   xfer;
        logic [7:0]             cfg;
        logic [DW-1:0]          sper;
        logic [DW-1:0]          aper;
        logic [DW-1:0]          cnt;
        logic [NCH-1:0][DW-1:0] scmp;
        logic [NCH-1:0][DW-1:0] acmp;
    } regs_t;

    regs_t s_d, s_q;
    logic  ctrl_wr, wrap, load;

    always_comb begin
        s_d     = s_q;
        ctrl_wr = wr_en && (wr_addr == AW'(ADDR_CTRL));
        wrap    = s_q.run && (s_q.cnt == s_q.aper);
        load    = s_q.xfer && (!s_q.run || wrap);

        if (!s_q.run || wrap) s_d.cnt = '0;
        else                  s_d.cnt = s_q.cnt + 1'b1;

        if (load) begin
            s_d.aper = s_q.sper;
            s_d.acmp = s_q.scmp;
            s_d.xfer = 1'b0;
        end

        if (ctrl_wr) begin
            s_d.run = wr_data[CTRL_RUN];
            s_d.len = wr_data[CTRL_LEN];
            if (wr_data[CTRL_XFER]) s_d.xfer = 1'b1;
        end
        if (wr_en && wr_addr == AW'(ADDR_BRK)) s_d.cfg  = wr_data[7:0];
        if (wr_en && wr_addr == AW'(ADDR_PER)) s_d.sper = wr_data;
        for (int i = 0; i < NCH; i++) begin
            if (wr_en && wr_addr == AW'(ADDR_CMP0 + i)) s_d.scmp[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADDR_CTRL)) begin
            rd_data[CTRL_RUN]  = s_q.run;
            rd_data[CTRL_LEN]  = s_q.len;
            rd_data[CTRL_XFER] = s_q.xfer;
            rd_data[CTRL_LST]  = latch_i;
        end else if (rd_addr == AW'(ADDR_BRK)) begin
            rd_data[7:0] = s_q.cfg;
        end else if (rd_addr == AW'(ADDR_PER)) begin
            rd_data = s_q.sper;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (rd_addr == AW'(ADDR_CMP0 + i)) rd_data = s_q.scmp[i];
            end
        end
    end

    assign run_o = s_q.run;
    assign len_o = s_q.len;
    assign clr_o = ctrl_wr && wr_data[CTRL_CLR];
    assign cfg_o = s_q.cfg;
    assign cnt_o = s_q.cnt;
    assign cmp_o = s_q.acmp;

    // R2: counter never passes the active period
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= s_q.aper);
    // R2: a stopped generator parks the counter at zero
    a_r2_stopped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.run |=> s_q.cnt == '0);
    // R3: while stopped a pending transfer completes on the next cycle
    a_r3_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.xfer && !s_q.run && !ctrl_wr) |=> !s_q.xfer);
    // R3: while running a pending transfer waits for the wrap
    a_r3_wait_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.xfer && s_q.run && s_q.cnt != s_q.aper) |=> s_q.xfer);
endmodule

// File: rtl/pwmb_brake.sv
module pwmb_brake
    import pwmb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [7:0] cfg_i,
    input  logic       run_i,
    input  logic       len_i,
    input  logic       clr_i,
    output logic       brake_o,
    output logic       latch_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic latch;
    } brk_t;

    brk_t        b_d, b_q;
    logic        pin_act, pin_src;
    brake_mode_e mode;

    always_comb begin
        b_d      = b_q;
        b_d.s1   = pin_i;
        b_d.s2   = b_q.s1;
        pin_act  = (b_q.s2 == cfg_i[BRK_POL]);
        pin_src  = pin_act || b_q.latch;
        mode     = brake_mode_e'({cfg_i[BRK_MODE_HI], cfg_i[BRK_MODE_LO]});

        if (clr_i)                 b_d.latch = 1'b0;
        else if (len_i && pin_act) b_d.latch = 1'b1;

        brake_o = 1'b0;
        if (cfg_i[BRK_EN]) begin
            unique case (mode)
                BM_ALWAYS: brake_o = 1'b1;
                BM_IDLE:   brake_o = !run_i;
                BM_PIN:    brake_o = pin_src;
                BM_RSVD:   brake_o = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign latch_o = b_q.latch;

    // R10: latch stays set until a clear write
    a_r10_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (b_q.latch && !clr_i) |=> b_q.latch);
    // R10: an active pin with latching enabled captures the latch
    a_r10_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
        (len_i && (b_q.s2 == cfg_i[BRK_POL]) && !clr_i) |=> b_q.latch);
endmodule

// File: rtl/pwmb_chan.sv
module pwmb_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cnt_i,
    input  logic [DW-1:0] cmp_i,
    input  logic          brake_i,
    input  logic          level_i,
    output logic          pwm_o
);
    typedef struct packed {
        logic pwm;
    } chan_t;

    chan_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.pwm = brake_i ? level_i : (cnt_i < cmp_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pwm_o = c_q.pwm;

    // R9: a braked cycle yields the programmed level on the next cycle
    a_r9_forced_level: assert property (@(posedge clk) disable iff (!rst_n)
        brake_i |=> pwm_o == $past(level_i));
    // R2: a zero compare never produces a high output
    a_r2_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!brake_i && cmp_i == '0) |=> !pwm_o);
endmodule

// File: rtl/pwmb_top.sv
module pwmb_top #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int AW = $clog2(NCH + 3)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    input  logic           brake_pin,
    output logic [NCH-1:0] pwm_o
);
    logic                   run, len, clr, brake, latch;
    logic [7:0]             cfg;
    logic [DW-1:0]          cnt;
    logic [NCH-1:0][DW-1:0] cmp;

    pwmb_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .latch_i (latch),
        .run_o   (run),
        .len_o   (len),
        .clr_o   (clr),
        .cfg_o   (cfg),
        .cnt_o   (cnt),
        .cmp_o   (cmp)
    );

    pwmb_brake u_brake (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (brake_pin),
        .cfg_i   (cfg),
        .run_i   (run),
        .len_i   (len),
        .clr_i   (clr),
        .brake_o (brake),
        .latch_o (latch)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pwmb_chan #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_i   (cnt),
            .cmp_i   (cmp[g]),
            .brake_i (brake),
            .level_i (cfg[g]),
            .pwm_o   (pwm_o[g])
        );
    end
endmodule

// File: tb/pwmb_top_bench.sv
module pwmb_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       brake_pin = 1'b0;
    logic [3:0] pwm_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit chk_en = 1'b0;

    pwmb_top u_pwmb_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .brake_pin(brake_pin), .pwm_o(pwm_o)
    );

    always #5 clk = ~clk;

    // reference model state
    logic       m_run, m_len, m_xfer, m_latch, m_s1, m_s2;
    logic [7:0] m_cfg, m_sper, m_aper, m_cnt;
    logic [7:0] m_scmp [4];
    logic [7:0] m_acmp [4];
    logic [3:0] m_pwm;
    logic       m_brk_last;

    function automatic logic f_brake(input logic [7:0] cfg, input logic run,
                                     input logic src);
        if (!cfg[4]) return 1'b0;
        case ({cfg[7], cfg[5]})
            2'b00:   return 1'b1;
            2'b01:   return !run;
            2'b10:   return src;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string f_tag(input logic [7:0] cfg, input logic brk);
        if (!brk || !cfg[4]) return "R2";
        case ({cfg[7], cfg[5]})
            2'b00:   return "R5";
            2'b01:   return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_len = 0; m_xfer = 0; m_latch = 0; m_s1 = 0; m_s2 = 0;
            m_cfg = 0; m_sper = 0; m_aper = 0; m_cnt = 0; m_pwm = 0;
            m_brk_last = 0;
            for (int i = 0; i < 4; i++) begin m_scmp[i] = 0; m_acmp[i] = 0; end
        end else begin
            logic pact, roll, ld, clr, brk, nlatch;
            logic [7:0] ncnt;
            logic [3:0] npwm;
            pact = (m_s2 == m_cfg[6]);
            roll = m_run && (m_cnt == m_aper);
            ld   = m_xfer && (!m_run || roll);
            clr  = wr_en && wr_addr == 3'd0 && wr_data[2];
            brk  = f_brake(m_cfg, m_run, pact || m_latch);
            for (int i = 0; i < 4; i++) npwm[i] = brk ? m_cfg[i] : (m_cnt < m_acmp[i]);
            ncnt   = (!m_run || roll) ? 8'd0 : m_cnt + 8'd1;
            nlatch = clr ? 1'b0 : ((m_len && pact) ? 1'b1 : m_latch);
            if (ld) begin
                m_aper = m_sper;
                for (int i = 0; i < 4; i++) m_acmp[i] = m_scmp[i];
                m_xfer = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin
                        m_run = wr_data[0]; m_len = wr_data[1];
                        if (wr_data[6]) m_xfer = 1;
                    end
                    3'd1: m_cfg = wr_data;
                    3'd2: m_sper = wr_data;
                    3'd3, 3'd4, 3'd5, 3'd6: m_scmp[wr_addr - 3'd3] = wr_data;
                    default: ;
                endcase
            end
            m_s2 = m_s1; m_s1 = brake_pin;
            m_cnt = ncnt; m_pwm = npwm; m_latch = nlatch;
            m_brk_last = brk;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %02h expected %02h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_en) begin
            check(f_tag(m_cfg, m_brk_last), {4'b0, pwm_o}, {4'b0, m_pwm});
            if (rd_addr == 3'd0) begin
                logic [7:0] ex;
                ex = {m_latch, m_xfer, 4'b0, m_len, m_run};
                check((rd_data[6] !== ex[6]) ? "R3" : "R10", rd_data, ex);
            end
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual %0d expected below 150000", cyc);
            report();
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
        rd_addr = 3'd0;
    endtask

    initial begin
        int hi [4];
        int waitc;
        void'($urandom(32'd20240611));
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        for (int a = 0; a < 7; a++) rd_chk("R1", 3'(a), 8'h00);
        check("R1", {4'b0, pwm_o}, 8'h00);
        chk_en = 1;

        // R11 / R7: pin latency with high polarity, stopped, zero compares
        wr(3'd1, 8'hDF);
        brake_pin = 1;
        tick(2);
        check("R11", {4'b0, pwm_o}, 8'h00);
        tick(1);
        check("R11", {4'b0, pwm_o}, 8'h0F);
        brake_pin = 0;
        tick(3);
        check("R7", {4'b0, pwm_o}, 8'h00);

        // R5 / R9 software brake with pattern A
        wr(3'd1, 8'h1A);
        tick(1);
        check("R9", {4'b0, pwm_o}, 8'h0A);
        // R4 enable off
        wr(3'd1, 8'h0F);
        tick(1);
        check("R4", {4'b0, pwm_o}, 8'h00);
        // R8 reserved mode
        wr(3'd1, 8'hBF);
        tick(1);
        check("R8", {4'b0, pwm_o}, 8'h00);
        // R6 brake while stopped, pin level irrelevant
        wr(3'd1, 8'h35);
        brake_pin = 1;
        tick(4);
        check("R6", {4'b0, pwm_o}, 8'h05);
        brake_pin = 0;

        // R10 latch captures a one-cycle pulse
        wr(3'd1, 8'hDF);
        wr(3'd0, 8'h02);
        brake_pin = 1;
        tick(1);
        brake_pin = 0;
        tick(6);
        check("R10", {4'b0, pwm_o}, 8'h0F);
        rd_chk("R10", 3'd0, 8'h82);
        wr(3'd0, 8'h06);
        tick(1);
        check("R10", {4'b0, pwm_o}, 8'h00);
        wr(3'd0, 8'h00);

        // R3 stopped transfer, then R2 duty over one period
        wr(3'd1, 8'h00);
        wr(3'd2, 8'd9);
        wr(3'd3, 8'd0); wr(3'd4, 8'd3); wr(3'd5, 8'd9); wr(3'd6, 8'd12);
        wr(3'd0, 8'h40);
        rd_chk("R3", 3'd0, 8'h40);
        tick(1);
        rd_chk("R3", 3'd0, 8'h00);
        wr(3'd0, 8'h01);
        tick(3);
        for (int i = 0; i < 4; i++) hi[i] = 0;
        for (int k = 0; k < 10; k++) begin
            tick(1);
            for (int i = 0; i < 4; i++) hi[i] += int'(pwm_o[i]);
        end
        check("R2", 8'(hi[0]), 8'd0);
        check("R2", 8'(hi[1]), 8'd3);
        check("R2", 8'(hi[2]), 8'd9);
        check("R2", 8'(hi[3]), 8'd10);
        // R3 running transfer waits for the wrap
        wr(3'd2, 8'd5);
        wr(3'd0, 8'h41);
        waitc = 0;
        while (rd_data[6] === 1'b1 && waitc < 30) begin tick(1); waitc++; end
        check("R3", 8'(waitc <= 10), 8'd1);

        // constrained random mix
        for (int it = 0; it < 4000; it++) begin
            int r;
            r = int'($urandom % 8);
            case (r)
                0: wr(3'd2, 8'($urandom % 16));
                1: wr(3'(3 + $urandom % 4), 8'($urandom % 18));
                2: wr(3'd0, 8'($urandom) & 8'h7F);
                3: wr(3'd1, 8'($urandom));
                4: begin tick(1); brake_pin = ~brake_pin; end
                5: begin tick(1); brake_pin = ~brake_pin; tick(1); brake_pin = ~brake_pin; end
                6: tick(1 + int'($urandom % 20));
                default: begin
                    waitc = 0;
                    while (m_xfer && waitc < 40) begin tick(1); waitc++; end
                    wr(3'd2, 8'($urandom % 16));
                    wr(3'(3 + $urandom % 4), 8'($urandom % 18));
                    wr(3'd0, 8'h41 | (8'($urandom) & 8'h02));
                end
            endcase
        end
        tick(5);
        report();
        $finish;
    end
endmodule